// File: doc/BRIEF.md
# Heartbeat Watchdog Supervisor

A synchronous watchdog supervisor for a processor subsystem. The supervised software toggles the `beat` input from time to time. If `beat` holds one level for longer than the selected timeout, the block drives the active-low `alarm_n` output low for a fixed pulse. That pulse can reset the processor or raise an interrupt. A free-running clock drives everything. A prescaler turns `CLK_PER_TICK` clock cycles into one time unit of 100 µs, and every duration is a whole number of these units.

A 3-bit timing select, `tsel`, picks the startup delay and the timeout. The values come from one of three built-in tables, chosen by the `VARIANT` parameter:

- In variant 0, the startup delay equals the timeout.
- In variant 1, the startup delay is fixed and long.
- Variant 2 has short startup delays and two codes that wait for the first heartbeat edge before timing begins.

After reset, and after every change of `tsel`, the block runs through these phases in order:

1. A short setup interval.
2. The startup phase.
3. Monitoring.

Code 011 turns the supervisor off. The select code may change while the block is running.

Top module: `beat_watchdog`

## Requirements
- R1: During reset and in the cycle after it, `alarm_n` is high. Reset latches code 000 and starts the setup interval, which lasts SETUP_U units.
- R2: In monitoring, a valid `beat` edge of either polarity restarts the full timeout. If no valid edge arrives within timeout × CLK_PER_TICK cycles of the last restart, `alarm_n` falls at exactly that cycle.
- R3: The alarm pulse lasts 10 units when SHORT_PULSE=1 and 1000 units otherwise. When `alarm_n` rises again, a full new timeout starts.
- R4: `beat` edges have no effect during the setup interval, during a timed startup, and while `alarm_n` is low.
- R5: No alarm pulse is produced during setup or startup. The timeout count starts only when startup ends.
- R6: `tsel`=011 turns the block off with `alarm_n` held high. Any other code brings the block back through setup and then startup, with no reset.
- R7: Timeout and startup lengths in units, for codes 000/001/010/100/101/110/111:
  - Variant 0: timeout 10/100/300/1000/10000/100000/600000, and startup equals timeout.
  - Variant 1: timeout 10/30/100/1000/3000/30000/600000, and startup 600000 for every code.
  - Variant 2: timeout 30/30000/10000/300/10000/100000/100000, and startup 30/30000/600000/2/-/-/600000.
- R8: In variant 2, codes 101 and 110 have no timed startup. After setup, the block waits without limit until the first valid `beat` edge, and that edge starts the timeout.
- R9: A `tsel` change made while `alarm_n` is low lets the pulse run its full width. The new code then enters setup and startup.
- R10: A `tsel` change made while `alarm_n` is high takes effect at once. The new setup interval starts two cycles after the first clock edge that samples the new code.
- R11: A level on `beat` counts as an edge only after it has held for MIN_BEAT_CLKS consecutive cycles. The edge acts MIN_BEAT_CLKS+1 cycles after the first clock edge that samples the new level. Shorter pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset, models power-up |
| beat | input | 1 | Heartbeat from the supervised software, asynchronous |
| tsel | input | 3 | Timing select code, asynchronous, may change at any time |
| alarm_n | output | 1 | Active-low timeout pulse |

## Verification
Wrong internal state shows at `alarm_n` as a wrong pulse width or as a pulse that falls earlier or later than expected. A timer or prescaler off by one moves the fall by CLK_PER_TICK cycles, and this shows on the very next timeout. A wrong phase shows as early pulses during startup, or as no pulse where one is due. The most serious case is a wrong code latched or a select change handled wrongly. It can stay hidden until the next timeout, which may be thousands of cycles later. For that reason, each scenario measures the exact distance from its last stimulus to the next fall and rise of `alarm_n`.

// File: rtl/beat_watchdog.sv
module beat_watchdog #(
  parameter int VARIANT       = 0,
  parameter int CLK_PER_TICK  = 12500,
  parameter int MIN_BEAT_CLKS = 13,
  parameter int SETUP_U       = 3,
  parameter bit SHORT_PULSE   = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       beat,
  input  logic [2:0] tsel,
  output logic       alarm_n
);
  localparam int MAX_U   = 600000;
  localparam int CW      = $clog2(MAX_U + 1);
  localparam int PW      = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam int GW      = (MIN_BEAT_CLKS > 1) ? $clog2(MIN_BEAT_CLKS) : 1;
  localparam int PULSE_U = SHORT_PULSE ? 10 : 1000;
  localparam logic [2:0] OFF_CODE = 3'b011;

  typedef enum logic [2:0] {S_SETUP, S_START, S_WAIT1, S_RUN, S_FAULT, S_OFF} phase_t;

  function automatic int unsigned tmo_u(input logic [2:0] c);
    if (VARIANT == 1) begin
      case (c)
        3'b000:  return 10;
        3'b001:  return 30;
        3'b010:  return 100;
        3'b100:  return 1000;
        3'b101:  return 3000;
        3'b110:  return 30000;
        default: return 600000;
      endcase
    end else if (VARIANT == 2) begin
      case (c)
        3'b000:  return 30;
        3'b001:  return 30000;
        3'b010:  return 10000;
        3'b100:  return 300;
        3'b101:  return 10000;
        default: return 100000;
      endcase
    end else begin
      case (c)
        3'b000:  return 10;
        3'b001:  return 100;
        3'b010:  return 300;
        3'b100:  return 1000;
        3'b101:  return 10000;
        3'b110:  return 100000;
        default: return 600000;
      endcase
    end
  endfunction

  function automatic int unsigned dly_u(input logic [2:0] c);
    if (VARIANT == 1) return 600000;
    if (VARIANT == 2) begin
      case (c)
        3'b000:  return 30;
        3'b001:  return 30000;
        3'b100:  return 2;
        default: return 600000;
      endcase
    end
    return tmo_u(c);
  endfunction

  function automatic logic waits_edge(input logic [2:0] c);
    return (VARIANT == 2) && (c == 3'b101 || c == 3'b110);
  endfunction

  logic [1:0]    beat_sy;
  logic [2:0]    tsel_m, tsel_q, cur_sel;
  logic          beat_f;
  logic [GW-1:0] gcnt;
  logic [PW-1:0] pre;
  logic [CW-1:0] tmr, nlen;
  phase_t        state, nstate;
  logic          load, take;

  wire beat_q    = beat_sy[1];
  wire differ    = beat_q != beat_f;
  wire beat_edge = differ && (gcnt == GW'(MIN_BEAT_CLKS - 1));
  wire tick      = (pre == PW'(CLK_PER_TICK - 1));
  wire done      = tick && (tmr == CW'(1));
  wire chg       = tsel_q != cur_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_sy <= '0;
      tsel_m  <= '0;
      tsel_q  <= '0;
    end else begin
      beat_sy <= {beat_sy[0], beat};
      tsel_m  <= tsel;
      tsel_q  <= tsel_m;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_f <= 1'b0;
      gcnt   <= '0;
    end else if (!differ) begin
      gcnt   <= '0;
    end else if (beat_edge) begin
      beat_f <= beat_q;
      gcnt   <= '0;
    end else begin
      gcnt   <= gcnt + GW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load) pre <= '0;
    else if (tick)   pre <= '0;
    else             pre <= pre + PW'(1);
  end

  always_comb begin
    nstate = state;
    nlen   = '0;
    load   = 1'b0;
    take   = 1'b0;
    if (chg && (state != S_FAULT || done)) begin
      take = 1'b1;
      load = 1'b1;
      if (tsel_q == OFF_CODE) nstate = S_OFF;
      else begin
        nstate = S_SETUP;
        nlen   = CW'(SETUP_U);
      end
    end else begin
      case (state)
        S_SETUP: if (done) begin
          load = 1'b1;
          if (waits_edge(cur_sel)) nstate = S_WAIT1;
          else begin
            nstate = S_START;
            nlen   = CW'(dly_u(cur_sel));
          end
        end
        S_START: if (done) begin
          load   = 1'b1;
          nstate = S_RUN;
          nlen   = CW'(tmo_u(cur_sel));
        end
        S_WAIT1: if (beat_edge) begin
          load   = 1'b1;
          nstate = S_RUN;
          nlen   = CW'(tmo_u(cur_sel));
        end
        S_RUN: if (beat_edge) begin
          load = 1'b1;
          nlen = CW'(tmo_u(cur_sel));
        end else if (done) begin
          load   = 1'b1;
          nstate = S_FAULT;
          nlen   = CW'(PULSE_U);
        end
        S_FAULT: if (done) begin
          load   = 1'b1;
          nstate = S_RUN;
          nlen   = CW'(tmo_u(cur_sel));
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_SETUP;
      tmr     <= CW'(SETUP_U);
      cur_sel <= '0;
    end else begin
      state <= nstate;
      if (take) cur_sel <= tsel_q;
      if (load) tmr <= nlen;
      else if (tick && tmr != '0) tmr <= tmr - CW'(1);
    end
  end

  assign alarm_n = (state != S_FAULT);

  // R5
  fall_from_run_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm_n) |-> $past(state) == S_RUN);

  // R9
  pulse_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_FAULT && !done) |=> (state == S_FAULT && $stable(cur_sel)));

  // R10
  change_acts_chk: assert property (@(posedge clk) disable iff (rst)
    (chg && state != S_FAULT) |=> ((state == S_SETUP || state == S_OFF) && cur_sel == $past(tsel_q)));

  // R6
  off_high_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_OFF) |-> (cur_sel == OFF_CODE && alarm_n));

  // R2
  beat_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_RUN && beat_edge && !chg) |=> (state == S_RUN && alarm_n));

  // R11
  glitch_level_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_edge && MIN_BEAT_CLKS > 1) |-> $past(beat_q) == beat_q);

  // R8
  wait_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT1) |-> waits_edge(cur_sel));
endmodule

// File: tb/beat_watchdog_test.sv
module beat_watchdog_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       beat = 1'b0;
  logic [2:0] tsel = 3'b000;
  logic       alarm_n;
  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  beat_watchdog #(
    .VARIANT(2), .CLK_PER_TICK(2), .MIN_BEAT_CLKS(3), .SETUP_U(3), .SHORT_PULSE(1'b1)
  ) uut (
    .clk(clk), .rst(rst), .beat(beat), .tsel(tsel), .alarm_n(alarm_n)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic find_low(input int max, output int idx);
    idx = -1;
    for (int i = 1; i <= max; i++) begin
      step(1);
      if (!alarm_n) begin
        idx = i;
        return;
      end
    end
  endtask

  task automatic run_len(input logic lvl, input int max, output int n);
    n = 1;
    for (int i = 0; i < max; i++) begin
      step(1);
      if (alarm_n != lvl) return;
      n++;
    end
  endtask

  task automatic quiet_for(input int cycles, output int lows);
    lows = 0;
    for (int i = 0; i < cycles; i++) begin
      step(1);
      if (!alarm_n) lows++;
    end
  endtask

  task automatic t_reset_and_pulse;
    int idx, n;
    step(5);
    rst = 1'b0;
    check("R1", "alarm_n after reset", alarm_n, 1);
    find_low(400, idx);
    check("R5", "first fall after reset", idx, 126);
    run_len(1'b0, 100, n);
    check("R3", "pulse width", n, 20);
    run_len(1'b1, 400, n);
    check("R3", "timeout after pulse", n, 60);
  endtask

  task automatic t_fault_ignores_beat;
    int n;
    beat = ~beat;
    run_len(1'b0, 100, n);
    check("R4", "pulse width with beat edge inside", n, 20);
    run_len(1'b1, 400, n);
    check("R4", "timeout after pulse with ignored edge", n, 60);
  endtask

  task automatic t_heartbeat;
    int n, lows, idx;
    run_len(1'b0, 100, n);
    lows = 0;
    for (int i = 0; i < 8; i++) begin
      int l;
      beat = ~beat;
      quiet_for(40, l);
      lows += l;
    end
    check("R2", "lows while beating", lows, 0);
    beat = ~beat;
    find_low(400, idx);
    check("R2", "fall after last edge", idx, 65);
  endtask

  task automatic t_glitch;
    int n, idx;
    run_len(1'b0, 100, n);
    beat = ~beat;
    step(20);
    beat = ~beat;
    step(2);
    beat = ~beat;
    find_low(400, idx);
    check("R11", "two-cycle glitch ignored", idx, 43);
    run_len(1'b0, 100, n);
    beat = ~beat;
    step(20);
    beat = ~beat;
    step(3);
    beat = ~beat;
    find_low(400, idx);
    check("R11", "three-cycle pulse accepted", idx, 65);
  endtask

  task automatic t_disable;
    int n, lows, idx;
    run_len(1'b0, 100, n);
    tsel = 3'b011;
    step(100);
    beat = ~beat;
    quiet_for(300, lows);
    check("R6", "lows while off", lows, 0);
    tsel = 3'b000;
    beat = ~beat;
    step(30);
    beat = ~beat;
    find_low(400, idx);
    check("R10", "fall after re-enable with ignored startup edges", idx, 99);
  endtask

  task automatic t_change_in_fault;
    int n;
    tsel = 3'b100;
    run_len(1'b0, 100, n);
    check("R9", "pulse completes after change", n, 20);
    run_len(1'b1, 2000, n);
    check("R7", "setup+startup+timeout for code 100", n, 610);
  endtask

  task automatic t_first_edge;
    int n, lows, idx;
    run_len(1'b0, 100, n);
    tsel = 3'b101;
    quiet_for(21000, lows);
    check("R8", "lows while waiting for first edge", lows, 0);
    beat = ~beat;
    find_low(25000, idx);
    check("R8", "fall after first edge", idx, 20005);
  endtask

  initial begin
    t_reset_and_pulse();
    t_fault_ignores_beat();
    t_heartbeat();
    t_glitch();
    t_disable();
    t_change_in_fault();
    t_first_edge();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule